// File: doc/BRIEF.md
# Prefetch Read Buffer

This block is a small fully associative store of data blocks, each holding up to eight words, kept in the data-read path in front of the caches. Each slot is addressed by a virtual address. A lookup is combinational. It compares the incoming virtual address against every valid slot and returns whether any slot covers that address. On a hit it also returns the index of the matching slot, the selected word, and the fault code that was recorded for the slot.

A slot is filled in one cycle through the load port. The load port gives the slot number, a size code, a start address and the block words. The fault code seen when the block was fetched is stored with the block. A later hit on that slot reports the fault, and the block's data is withheld. Fetching the block from memory is the job of the surrounding logic. Slots can be dropped one at a time or all together.

Top module: `pfrb_top`

## Requirements
- R1: After reset every slot is empty, and no lookup address hits.
- R2: A lookup hits when a valid slot's span contains the address. The block then returns the slot index, and when the stored fault is zero it asserts `lk_data_ok` with the selected word.
- R3: An address outside every valid span is a miss. On a miss `lk_data`, `lk_fault` and `lk_data_ok` are all zero.
- R4: The selected word index is (address AND (span_bytes − 1)) >> 2, so the two low address bits have no effect on the result.
- R5: When several slots cover the address, the slot with the lowest index is reported.
- R6: A hit on a slot with a nonzero stored fault returns that fault. In that case `lk_data_ok` is 0 and `lk_data` is zero.
- R7: A single invalidate of slot i empties only slot i from the next cycle on.
- R8: An invalidate-all empties every slot from the next cycle on.
- R9: When invalidate-all and a load arrive in the same cycle, the invalidate-all wins and the load is dropped.
- R10: When a single invalidate and a load name the same slot in the same cycle, the load wins and the slot is valid afterwards.
- R11: The stored start address is the load address with its bits below the span cleared. An unaligned load address therefore covers the aligned span around it.
- R12: The size code maps to a span as 0 → 1 word, 1 → 2 words, 2 → 4 words, 3 → 8 words, with 4-byte words. Word k of a block sits at `ld_block[32k+31:32k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | 32 | Lookup virtual byte address |
| lk_hit | output | 1 | Some valid slot covers `lk_va` |
| lk_idx | output | 2 | Index of the reporting slot (lowest hit) |
| lk_data | output | 32 | Selected word, zero unless `lk_data_ok` |
| lk_data_ok | output | 1 | Hit on a slot with zero fault |
| lk_fault | output | 4 | Fault code of the hit slot, zero on miss |
| ld_en | input | 1 | Load a slot this cycle |
| ld_idx | input | 2 | Slot to load |
| ld_type | input | 2 | Size code of the loaded block |
| ld_va | input | 32 | Start virtual address of the block |
| ld_block | input | 256 | Block words, word k at bits 32k+31:32k |
| ld_fault | input | 4 | Fault code captured with the block |
| inv_one_en | input | 1 | Invalidate one slot this cycle |
| inv_idx | input | 2 | Slot to invalidate |
| inv_all_en | input | 1 | Invalidate every slot this cycle |

## Verification
The properties assume that the command inputs are never unknown while reset is released and that the slot indices are always in range. With the default widths, two index bits cover exactly four slots. The properties also assume that `lk_va` is held steady across the clock edge, so that a post-edge property sees the same address that was presented before the edge. The bench drives every command and the lookup address only at the falling edge, and it clears the commands after one cycle. It keeps every lookup and load address inside a small window, so random traffic produces hits, overlapping slots and faulted slots.

// File: rtl/pfrb_pkg.sv
`timescale 1ns/1ps
package pfrb_pkg;
   // Per-slot action decoded at the top for one clock cycle
   typedef enum logic [1:0] {
      SLOT_KEEP  = 2'd0,
      SLOT_FILL  = 2'd1,
      SLOT_EMPTY = 2'd2
   } slot_op_e;
endpackage

// File: rtl/pfrb_slot.sv
`timescale 1ns/1ps
module pfrb_slot
   import pfrb_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int WORDS   = 8,
   parameter int FAULT_W = 4,
   parameter int TYPE_W  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  slot_op_e                  op,
   input  logic [TYPE_W-1:0]         ld_type,
   input  logic [ADDR_W-1:0]         ld_va,
   input  logic [WORDS*DATA_W-1:0]   ld_block,
   input  logic [FAULT_W-1:0]        ld_fault,
   input  logic [ADDR_W-1:0]         lk_va,
   output logic                      hit,
   output logic [DATA_W-1:0]         word,
   output logic [FAULT_W-1:0]        fault
);
   localparam int LOG_WORDS = $clog2(WORDS);
   localparam int IDX_W     = (LOG_WORDS > 0) ? LOG_WORDS : 1;
   localparam int BSH       = $clog2(DATA_W / 8);

   // Byte mask covering one span; size codes beyond the array are clamped
   function automatic logic [ADDR_W-1:0] span_mask(input logic [TYPE_W-1:0] t);
      int unsigned sh;
      sh = (int'(t) > LOG_WORDS) ? LOG_WORDS : int'(t);
      return (ADDR_W'(1) << (sh + BSH)) - ADDR_W'(1);
   endfunction

   logic                valid_q;
   logic [ADDR_W-1:0]   base_q;
   logic [TYPE_W-1:0]   type_q;
   logic [FAULT_W-1:0]  fault_q;
   logic [DATA_W-1:0]   mem_q [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         base_q  <= '0;
         type_q  <= '0;
         fault_q <= '0;
      end else begin
         case (op)
            SLOT_FILL: begin
               valid_q <= 1'b1;
               base_q  <= ld_va & ~span_mask(ld_type);
               type_q  <= ld_type;
               fault_q <= ld_fault;
            end
            SLOT_EMPTY: valid_q <= 1'b0;
            default: ;
         endcase
      end
   end

   for (genvar k = 0; k < WORDS; k++) begin : g_word
      always_ff @(posedge clk) begin
         if (op == SLOT_FILL) mem_q[k] <= ld_block[k*DATA_W +: DATA_W];
      end
   end

   logic [ADDR_W-1:0] cur_mask;
   logic [IDX_W-1:0]  widx;

   always_comb begin
      cur_mask = span_mask(type_q);
      hit      = valid_q && ((lk_va & ~cur_mask) == base_q);
      widx     = IDX_W'((lk_va & cur_mask) >> BSH);
      word     = mem_q[widx];
      fault    = fault_q;
   end
endmodule

// File: rtl/pfrb_pick.sv
`timescale 1ns/1ps
module pfrb_pick #(
   parameter int N       = 4,
   parameter int DATA_W  = 32,
   parameter int FAULT_W = 4,
   parameter int IDX_W   = 2
) (
   input  logic [N-1:0]          hits,
   input  logic [N*DATA_W-1:0]   words,
   input  logic [N*FAULT_W-1:0]  faults,
   output logic                  any,
   output logic [IDX_W-1:0]      idx,
   output logic [DATA_W-1:0]     word,
   output logic [FAULT_W-1:0]    fault
);
   if (N == 1) begin : g_single
      always_comb begin
         any   = hits[0];
         idx   = '0;
         word  = hits[0] ? words[DATA_W-1:0] : '0;
         fault = hits[0] ? faults[FAULT_W-1:0] : '0;
      end
   end else begin : g_multi
      // Scan from the top down so the lowest hitting index is assigned last
      always_comb begin
         any   = |hits;
         idx   = '0;
         word  = '0;
         fault = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
               idx   = IDX_W'(i);
               word  = words[i*DATA_W +: DATA_W];
               fault = faults[i*FAULT_W +: FAULT_W];
            end
         end
      end
   end
endmodule

// File: rtl/pfrb_top.sv
`timescale 1ns/1ps
module pfrb_top
   import pfrb_pkg::*;
#(
   parameter int ENTRIES = 4,
   parameter int WORDS   = 8,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 32,
   parameter int FAULT_W = 4,
   localparam int ENT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int TYPE_W = ($clog2($clog2(WORDS) + 1) > 0) ? $clog2($clog2(WORDS) + 1) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        lk_va,
   output logic                     lk_hit,
   output logic [ENT_W-1:0]         lk_idx,
   output logic [DATA_W-1:0]        lk_data,
   output logic                     lk_data_ok,
   output logic [FAULT_W-1:0]       lk_fault,
   input  logic                     ld_en,
   input  logic [ENT_W-1:0]         ld_idx,
   input  logic [TYPE_W-1:0]        ld_type,
   input  logic [ADDR_W-1:0]        ld_va,
   input  logic [WORDS*DATA_W-1:0]  ld_block,
   input  logic [FAULT_W-1:0]       ld_fault,
   input  logic                     inv_one_en,
   input  logic [ENT_W-1:0]         inv_idx,
   input  logic                     inv_all_en
);
   // Elaboration-time parameter checks
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("pfrb_top: WORDS must be a power of two of at least 2");
   end
   if (DATA_W < 8 || (DATA_W % 8) != 0 || ((DATA_W / 8) & (DATA_W / 8 - 1)) != 0) begin : g_bad_data
      $error("pfrb_top: DATA_W must be a power-of-two number of bytes");
   end
   if (ENTRIES < 1) begin : g_bad_entries
      $error("pfrb_top: ENTRIES must be at least 1");
   end
   if (ADDR_W <= $clog2(WORDS) + $clog2(DATA_W / 8)) begin : g_bad_addr
      $error("pfrb_top: ADDR_W too narrow for the largest span");
   end

   slot_op_e                    ops   [ENTRIES];
   logic [ENTRIES-1:0]          hits;
   logic [ENTRIES*DATA_W-1:0]   words;
   logic [ENTRIES*FAULT_W-1:0]  faults;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      // Priority: invalidate-all, then load, then single invalidate
      always_comb begin
         if (inv_all_en)                               ops[i] = SLOT_EMPTY;
         else if (ld_en && ld_idx == ENT_W'(i))         ops[i] = SLOT_FILL;
         else if (inv_one_en && inv_idx == ENT_W'(i))   ops[i] = SLOT_EMPTY;
         else                                          ops[i] = SLOT_KEEP;
      end

      pfrb_slot #(
         .ADDR_W (ADDR_W),
         .DATA_W (DATA_W),
         .WORDS  (WORDS),
         .FAULT_W(FAULT_W),
         .TYPE_W (TYPE_W)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .op      (ops[i]),
         .ld_type (ld_type),
         .ld_va   (ld_va),
         .ld_block(ld_block),
         .ld_fault(ld_fault),
         .lk_va   (lk_va),
         .hit     (hits[i]),
         .word    (words[i*DATA_W +: DATA_W]),
         .fault   (faults[i*FAULT_W +: FAULT_W])
      );
   end

   logic                any_hit;
   logic [DATA_W-1:0]   sel_word;
   logic [FAULT_W-1:0]  sel_fault;

   pfrb_pick #(
      .N      (ENTRIES),
      .DATA_W (DATA_W),
      .FAULT_W(FAULT_W),
      .IDX_W  (ENT_W)
   ) u_pick (
      .hits  (hits),
      .words (words),
      .faults(faults),
      .any   (any_hit),
      .idx   (lk_idx),
      .word  (sel_word),
      .fault (sel_fault)
   );

   always_comb begin
      lk_hit     = any_hit;
      lk_fault   = any_hit ? sel_fault : '0;
      lk_data_ok = any_hit && (sel_fault == '0);
      lk_data    = (any_hit && (sel_fault == '0)) ? sel_word : '0;
   end
endmodule

// File: rtl/pfrb_checker.sv
`timescale 1ns/1ps
module pfrb_checker #(
   parameter int DATA_W  = 32,
   parameter int FAULT_W = 4,
   parameter int ENT_W   = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_hit,
   input logic [ENT_W-1:0]   lk_idx,
   input logic [DATA_W-1:0]  lk_data,
   input logic               lk_data_ok,
   input logic [FAULT_W-1:0] lk_fault,
   input logic               ld_en,
   input logic [ENT_W-1:0]   ld_idx,
   input logic               inv_one_en,
   input logic [ENT_W-1:0]   inv_idx,
   input logic               inv_all_en
);
   // R2: data may only be offered on a hit
   p_ok_needs_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_data_ok |-> lk_hit);

   // R3: a miss reports neither data nor fault
   p_miss_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_fault == '0 && lk_data == '0 && !lk_data_ok));

   // R6: a recorded fault suppresses the data
   p_fault_blocks_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_fault != '0) |-> (lk_hit && !lk_data_ok && lk_data == '0));

   // R8 and R9: after invalidate-all nothing hits, even with a load in the same cycle
   p_inv_all_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all_en |=> !lk_hit);

   // R7: an invalidated slot cannot be the reporting slot on the next cycle
   p_inv_one_gone_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_one_en && !inv_all_en && !(ld_en && ld_idx == inv_idx))
      |=> !(lk_hit && lk_idx == $past(inv_idx)));
endmodule

bind pfrb_top pfrb_checker #(
   .DATA_W (DATA_W),
   .FAULT_W(FAULT_W),
   .ENT_W  (ENT_W)
) u_pfrb_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .lk_hit    (lk_hit),
   .lk_idx    (lk_idx),
   .lk_data   (lk_data),
   .lk_data_ok(lk_data_ok),
   .lk_fault  (lk_fault),
   .ld_en     (ld_en),
   .ld_idx    (ld_idx),
   .inv_one_en(inv_one_en),
   .inv_idx   (inv_idx),
   .inv_all_en(inv_all_en)
);

// File: tb/pfrb_top_bench.sv
`timescale 1ns/1ps
module pfrb_top_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [31:0]  lk_va = '0;
   logic         lk_hit;
   logic [1:0]   lk_idx;
   logic [31:0]  lk_data;
   logic         lk_data_ok;
   logic [3:0]   lk_fault;
   logic         ld_en = 1'b0;
   logic [1:0]   ld_idx = '0;
   logic [1:0]   ld_type = '0;
   logic [31:0]  ld_va = '0;
   logic [255:0] ld_block = '0;
   logic [3:0]   ld_fault = '0;
   logic         inv_one_en = 1'b0;
   logic [1:0]   inv_idx = '0;
   logic         inv_all_en = 1'b0;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pfrb_top u_pfrb_top (
      .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit), .lk_idx(lk_idx),
      .lk_data(lk_data), .lk_data_ok(lk_data_ok), .lk_fault(lk_fault),
      .ld_en(ld_en), .ld_idx(ld_idx), .ld_type(ld_type), .ld_va(ld_va),
      .ld_block(ld_block), .ld_fault(ld_fault), .inv_one_en(inv_one_en),
      .inv_idx(inv_idx), .inv_all_en(inv_all_en)
   );

   // Behavioural reference: four slots of up to eight words
   bit          m_valid [4];
   logic [31:0] m_base  [4];
   int          m_span  [4];
   logic [3:0]  m_fault [4];
   logic [31:0] m_data  [4][8];

   task automatic model_edge();
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) m_valid[i] = 1'b0;
      end else if (inv_all_en) begin
         for (int i = 0; i < 4; i++) m_valid[i] = 1'b0;
      end else begin
         if (inv_one_en && !(ld_en && ld_idx == inv_idx)) m_valid[inv_idx] = 1'b0;
         if (ld_en) begin
            m_valid[ld_idx] = 1'b1;
            m_span[ld_idx]  = 4 << ld_type;
            m_base[ld_idx]  = ld_va & ~(32'(4 << ld_type) - 32'd1);
            m_fault[ld_idx] = ld_fault;
            for (int k = 0; k < 8; k++) m_data[ld_idx][k] = ld_block[k*32 +: 32];
         end
      end
   endtask

   // One clock: present va, compare, take the edge, clear commands
   task automatic step(input string tag, input logic [31:0] va);
      bit          e_hit;
      int          e_idx;
      logic [31:0] e_data;
      logic [3:0]  e_fault;
      bit          e_ok;
      bit          bad;
      lk_va = va;
      #2;
      e_hit = 1'b0; e_idx = 0; e_fault = '0; e_data = '0;
      for (int i = 0; i < 4; i++) begin
         if (!e_hit && m_valid[i] &&
             ((va & ~(32'(m_span[i]) - 32'd1)) == m_base[i])) begin
            e_hit = 1'b1;
            e_idx = i;
         end
      end
      if (e_hit) e_fault = m_fault[e_idx];
      e_ok = e_hit && (e_fault == 0);
      if (e_ok) e_data = m_data[e_idx][(va & (32'(m_span[e_idx]) - 32'd1)) >> 2];
      bad = (lk_hit !== e_hit) || (e_hit && lk_idx !== 2'(e_idx)) ||
            (lk_fault !== e_fault) || (lk_data_ok !== e_ok) || (lk_data !== e_data);
      checks++;
      if (bad) begin
         errors++;
         $display("FAIL %s va=%h: got hit=%0b idx=%0d ok=%0b fault=%h data=%h, expected hit=%0b idx=%0d ok=%0b fault=%h data=%h",
                  tag, va, lk_hit, lk_idx, lk_data_ok, lk_fault, lk_data,
                  e_hit, e_idx, e_ok, e_fault, e_data);
      end
      @(posedge clk);
      model_edge();
      @(negedge clk);
      ld_en = 1'b0; inv_one_en = 1'b0; inv_all_en = 1'b0;
   endtask

   task automatic set_load(input int idx, input int typ, input logic [31:0] va,
                           input logic [3:0] f, input logic [31:0] seed);
      ld_en = 1'b1; ld_idx = 2'(idx); ld_type = 2'(typ); ld_va = va; ld_fault = f;
      for (int k = 0; k < 8; k++) ld_block[k*32 +: 32] = seed + 32'(k) * 32'h0101_0011;
   endtask

   task automatic set_inv(input int idx);
      inv_one_en = 1'b1; inv_idx = 2'(idx);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got no completion, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) begin
         m_valid[i] = 1'b0; m_base[i] = '0; m_span[i] = 4; m_fault[i] = '0;
         for (int k = 0; k < 8; k++) m_data[i][k] = '0;
      end
      @(negedge clk);
      step("R1 reset", 32'h0000_0000);
      step("R1 reset", 32'h0000_1000);
      rst_n = 1'b1;
      step("R1 after reset", 32'h0000_1000);

      // R12 / R2: eight-word block at 0x1000
      set_load(0, 3, 32'h0000_1000, 4'h0, 32'hA000_0000);
      step("R2 load", 32'h0000_1000);
      step("R2 first word", 32'h0000_1000);
      step("R4 last word", 32'h0000_101C);
      step("R4 low bits ignored", 32'h0000_1013);
      step("R3 above span", 32'h0000_1020);
      step("R3 below span", 32'h0000_0FFC);

      // R12: one, two and four word spans
      set_load(1, 0, 32'h0000_2004, 4'h0, 32'hB000_0000);
      step("R12 load", 32'h0000_2004);
      step("R12 one word", 32'h0000_2004);
      step("R12 one word edge", 32'h0000_2008);
      set_load(2, 1, 32'h0000_3008, 4'h0, 32'hC000_0000);
      step("R12 load", 32'h0000_3008);
      step("R12 two words", 32'h0000_300C);
      step("R12 two words edge", 32'h0000_3010);
      set_load(3, 2, 32'h0000_4010, 4'h0, 32'hD000_0000);
      step("R12 load", 32'h0000_4010);
      step("R12 four words", 32'h0000_401C);
      step("R12 four words edge", 32'h0000_4020);

      // R11: unaligned start address
      set_load(2, 2, 32'h0000_500C, 4'h0, 32'hE000_0000);
      step("R11 load", 32'h0000_5000);
      step("R11 aligned base", 32'h0000_5000);
      step("R11 unaligned word", 32'h0000_500C);

      // R5: overlapping slots, lowest index reported
      set_load(3, 3, 32'h0000_1000, 4'h0, 32'hF000_0000);
      step("R5 load", 32'h0000_1008);
      step("R5 lowest wins", 32'h0000_1008);
      set_inv(0);
      step("R7 invalidate one", 32'h0000_1008);
      step("R5 next slot reports", 32'h0000_1008);
      step("R7 other slot kept", 32'h0000_2004);

      // R6: faulted slot
      set_load(1, 1, 32'h0000_6000, 4'h5, 32'h1234_0000);
      step("R6 load", 32'h0000_6004);
      step("R6 fault reported", 32'h0000_6004);

      // R10: load and invalidate name the same slot
      set_load(0, 0, 32'h0000_7000, 4'h0, 32'h5555_0000);
      set_inv(0);
      step("R10 same slot", 32'h0000_7000);
      step("R10 load wins", 32'h0000_7000);

      // R9: invalidate-all beats a load
      set_load(2, 3, 32'h0000_8000, 4'h0, 32'h7777_0000);
      inv_all_en = 1'b1;
      step("R9 both", 32'h0000_8000);
      step("R9 load dropped", 32'h0000_8000);
      step("R8 all empty", 32'h0000_7000);
      step("R8 all empty", 32'h0000_1008);

      // Mixed traffic in a small window
      for (int n = 0; n < 600; n++) begin
         int r;
         r = int'($urandom % 16);
         if (r < 6) begin
            set_load(int'($urandom % 4), int'($urandom % 4),
                     32'h0000_1000 + 32'($urandom % 64) * 4 + 32'($urandom % 4),
                     ($urandom % 4 == 0) ? 4'($urandom % 16) : 4'h0, $urandom);
         end
         if (r >= 5 && r < 9) set_inv(int'($urandom % 4));
         if (r == 15 && ($urandom % 4 == 0)) inv_all_en = 1'b1;
         step("R2 mixed", 32'h0000_1000 + 32'($urandom % 80) * 4 + 32'($urandom % 4));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule